// File: doc/BRIEF.md
# Serial Clock Generator with Movable Sample Point

This block derives the serial clock of a SPI master from the system clock and marks, with one-cycle strobes, the system cycles in which the master should shift its next output bit and capture its next input bit. The clock divides the system clock by an even ratio chosen by a small code. The level the clock rests at between transfers follows the SPI mode bit.

The shift strobe always follows a falling serial edge. The sample strobe can be placed at one of three points in the serial period. This lets a master reading a slow or distant memory move its capture point later, so that it still meets the slave's output delay. Chip-select control and the data shift registers sit outside this block. They use the strobes as clock enables.

Top module: `spi_sclk_gen`

## Requirements
- R1: With a divide code n in 1..15, every half period of `sclk` while `run` is high lasts exactly n system clocks, giving a serial clock of the system clock divided by 2n.
- R2: Divide code 0 behaves as code 1: each half period is one system clock.
- R3: The first half period after `run` rises is spent at the idle level. Mode 0 (`mode`=0) idles `sclk` low and mode 3 (`mode`=1) idles it high.
- R4: One clock after `run` is sampled low, `sclk` equals the `mode` value sampled in that clock. While `run` is low, neither strobe is asserted.
- R5: `div_code` is captured only while `run` is low. A change made while running has no effect on the half-period length until the generator has returned to idle. A change of `mode` while running leaves `sclk` toggling unchanged and sets the idle level once `run` drops.
- R6: `shift_stb` is high for exactly the one system cycle that follows each falling edge of `sclk`.
- R7: With `samp_sel`=0, `sample_stb` is high for the one system cycle that follows each rising edge of `sclk`.
- R8: With `samp_sel`=1, `sample_stb` is high during the last system cycle of each high half of `sclk`, the cycle that ends with the falling edge.
- R9: With `samp_sel`=2, `sample_stb` is high for the one system cycle that follows each falling edge of `sclk`, coinciding with `shift_stb`.
- R10: `samp_sel`=3 behaves as `samp_sel`=0.
- R11: During reset `sclk` is low and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Generator enable; low holds the idle level |
| div_code | input | CODE_W | Half-period length in system clocks (0 treated as 1) |
| mode | input | 1 | 0: idle low (mode 0), 1: idle high (mode 3) |
| samp_sel | input | 2 | Sample strobe position, 0..3 as in R7 to R10 |
| sclk | output | 1 | Registered serial clock |
| shift_stb | output | 1 | One-cycle strobe after each falling serial edge |
| sample_stb | output | 1 | One-cycle strobe at the selected capture point |

## Verification
The bench compares every cycle of a run against a model built from the edge count since `run` rose. Several faults would show up there. An off-by-one divider would stretch each half period to n+1 clocks. A design that failed to map code 0 would stall or run at /32. A wrong start phase would begin mode 3 with a rising edge. The single-cycle half periods of code 0 are the sharpest test of the late-sample position, because there the late strobe shares its cycle with the after-rise strobe. The bench also changes the divide code and the mode during a run. A design that latched them at any time would change the period mid-transfer. Finally, dropping `run` in the middle of a half period exposes a strobe that leaks one cycle past the enable.

// File: rtl/spi_sclk_gen_pkg.sv
`timescale 1ns/1ps
package spi_sclk_gen_pkg;

  typedef enum logic [1:0] {
    SMP_AFTER_RISE = 2'd0,
    SMP_LATE_HIGH  = 2'd1,
    SMP_AFTER_FALL = 2'd2,
    SMP_SPARE      = 2'd3
  } smp_sel_e;

  // Half-period length in system clocks for a divide code; code 0 maps to 1.
  function automatic int unsigned half_cycles(input int unsigned code);
    return (code == 0) ? 1 : code;
  endfunction

  // Chooses which timing event drives the sample strobe.
  function automatic logic pick_sample(input logic [1:0] sel,
                                       input logic after_rise,
                                       input logic late_high,
                                       input logic after_fall);
    logic res;
    case (smp_sel_e'(sel))
      SMP_LATE_HIGH:  res = late_high;
      SMP_AFTER_FALL: res = after_fall;
      default:        res = after_rise;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/sclk_div_latch.sv
`timescale 1ns/1ps
module sclk_div_latch #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] div_code,
  output logic [CODE_W-1:0] div_q
);
  // Divide code is only taken while the generator is idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   div_q <= '0;
    else if (!run) div_q <= div_code;
  end
endmodule

// File: rtl/sclk_half_counter.sv
`timescale 1ns/1ps
module sclk_half_counter
  import spi_sclk_gen_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              idle_lvl,
  input  logic [CODE_W-1:0] div_q,
  output logic              sclk_q,
  output logic              half_wrap,
  output logic              rise_now,
  output logic              fall_now
);
  logic [CODE_W-1:0] cnt;
  logic [CODE_W-1:0] last_idx;

  assign last_idx  = CODE_W'(half_cycles(int'(div_q)) - 1);
  assign half_wrap = run && (cnt == last_idx);
  assign rise_now  = half_wrap && !sclk_q;
  assign fall_now  = half_wrap &&  sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      cnt    <= '0;
      sclk_q <= idle_lvl;
    end else if (half_wrap) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt    <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sclk_strobe_gen.sv
`timescale 1ns/1ps
module sclk_strobe_gen
  import spi_sclk_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       rise_now,
  input  logic       fall_now,
  input  logic [1:0] samp_sel,
  output logic       shift_stb,
  output logic       sample_stb
);
  logic after_rise_q;
  logic after_fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      after_rise_q <= 1'b0;
      after_fall_q <= 1'b0;
    end else begin
      after_rise_q <= run && rise_now;
      after_fall_q <= run && fall_now;
    end
  end

  assign shift_stb  = run && after_fall_q;
  assign sample_stb = run && pick_sample(samp_sel, after_rise_q, fall_now, after_fall_q);
endmodule

// File: rtl/spi_sclk_gen.sv
`timescale 1ns/1ps
module spi_sclk_gen #(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] div_code,
  input  logic              mode,
  input  logic [1:0]        samp_sel,
  output logic              sclk,
  output logic              shift_stb,
  output logic              sample_stb
);
  logic [CODE_W-1:0] div_q;
  logic              half_wrap;
  logic              rise_now;
  logic              fall_now;

  sclk_div_latch #(.CODE_W(CODE_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .run(run), .div_code(div_code), .div_q(div_q)
  );

  sclk_half_counter #(.CODE_W(CODE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run), .idle_lvl(mode), .div_q(div_q),
    .sclk_q(sclk), .half_wrap(half_wrap), .rise_now(rise_now), .fall_now(fall_now)
  );

  sclk_strobe_gen u_stb (
    .clk(clk), .rst_n(rst_n), .run(run), .rise_now(rise_now), .fall_now(fall_now),
    .samp_sel(samp_sel), .shift_stb(shift_stb), .sample_stb(sample_stb)
  );
endmodule

// File: rtl/spi_sclk_gen_chk.sv
`timescale 1ns/1ps
module spi_sclk_gen_chk
  import spi_sclk_gen_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              mode,
  input logic [1:0]        samp_sel,
  input logic              sclk,
  input logic              shift_stb,
  input logic              sample_stb,
  input logic              half_wrap,
  input logic [CODE_W-1:0] div_q
);
  logic [CODE_W-1:0] hc;
  logic [CODE_W-1:0] half_m1;

  assign half_m1 = CODE_W'(half_cycles(int'(div_q)) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hc <= '0;
    else if (!run)       hc <= '0;
    else if (half_wrap)  hc <= '0;
    else                 hc <= hc + 1'b1;
  end

  a_r1_half_len: assert property (@(posedge clk) disable iff (!rst_n)
    (run && half_wrap) |-> (hc == half_m1));
  a_r1_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (hc <= half_m1));
  a_r1_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (run && half_wrap) |=> (sclk != $past(sclk)));
  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !half_wrap) |=> $stable(sclk));
  a_r4_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (sclk == $past(mode)));
  a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!shift_stb && !sample_stb));
  a_r5_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run)) |-> $stable(div_q));
  a_r6_shift_single: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |=> !shift_stb);
  a_r6_shift_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    shift_stb |-> (!sclk && $past(sclk)));
  a_r7_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && (samp_sel == 2'd0)) |-> (sclk && !$past(sclk)));
  a_r8_late_high: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_stb && (samp_sel == 2'd1)) |=> !sclk);
  a_r9_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_sel == 2'd2) |-> (sample_stb == shift_stb));
endmodule

bind spi_sclk_gen spi_sclk_gen_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .mode(mode), .samp_sel(samp_sel),
  .sclk(sclk), .shift_stb(shift_stb), .sample_stb(sample_stb),
  .half_wrap(half_wrap), .div_q(div_q)
);

// File: tb/tb_spi_sclk_gen.sv
`timescale 1ns/1ps
module tb_spi_sclk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [3:0] div_code = 4'd0;
  logic       mode = 1'b0;
  logic [1:0] samp_sel = 2'd0;
  logic       sclk, shift_stb, sample_stb;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_sclk_gen dut (
    .clk(clk), .rst_n(rst_n), .run(run), .div_code(div_code), .mode(mode),
    .samp_sel(samp_sel), .sclk(sclk), .shift_stb(shift_stb), .sample_stb(sample_stb)
  );

  // {code[10:7], mode[6], sel[5:4], expected half length[3:0]}
  localparam logic [10:0] VEC [0:7] = '{
    {4'd1,  1'b0, 2'd0, 4'd1},
    {4'd0,  1'b0, 2'd1, 4'd1},
    {4'd3,  1'b1, 2'd1, 4'd3},
    {4'd15, 1'b0, 2'd2, 4'd15},
    {4'd5,  1'b1, 2'd2, 4'd5},
    {4'd2,  1'b0, 2'd3, 4'd2},
    {4'd7,  1'b1, 2'd0, 4'd7},
    {4'd4,  1'b0, 2'd1, 4'd4}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Runs ncyc cycles from idle, comparing against the edge-count model.
  // Model: after posedge k, toggles so far = (k+1)/n, level = mode ^ odd(toggles).
  task automatic run_model(input int n, input bit md, input int sel, input int ncyc,
                           input string stag);
    int bad_c = 0, bad_h = 0, bad_s = 0;
    int a_c = 0, e_c = 0, a_h = 0, e_h = 0, a_s = 0, e_s = 0;
    @(negedge clk) run = 1'b1;
    for (int k = 0; k < ncyc; k++) begin
      bit tog, lvl, e_rise, e_fall, e_late, e_samp;
      @(posedge clk);
      @(negedge clk);
      tog    = ((k + 1) % n) == 0;
      lvl    = md ^ (((k + 1) / n) % 2 == 1);
      e_rise = tog && lvl;
      e_fall = tog && !lvl;
      e_late = (((k + 2) % n) == 0) && lvl;
      e_samp = (sel == 1) ? e_late : (sel == 2) ? e_fall : e_rise;
      if (sclk != lvl && bad_c == 0) begin bad_c = 1; a_c = sclk; e_c = lvl; end
      if (shift_stb != e_fall && bad_h == 0) begin bad_h = 1; a_h = shift_stb; e_h = e_fall; end
      if (sample_stb != e_samp && bad_s == 0) begin bad_s = 1; a_s = sample_stb; e_s = e_samp; end
    end
    check(bad_c == 0, "R1 R2 R3", "sclk waveform", a_c, e_c);
    check(bad_h == 0, "R6", "shift strobe", a_h, e_h);
    check(bad_s == 0, stag, "sample strobe", a_s, e_s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    check(sclk == 1'b0, "R11", "sclk in reset", sclk, 0);
    check(!shift_stb && !sample_stb, "R11", "strobes in reset",
          int'(shift_stb) + int'(sample_stb), 0);
    rst_n = 1'b1;

    for (int v = 0; v < 8; v++) begin
      int sel;
      string stag;
      @(negedge clk);
      run      = 1'b0;
      div_code = VEC[v][10:7];
      mode     = VEC[v][6];
      samp_sel = VEC[v][5:4];
      sel      = int'(VEC[v][5:4]);
      stag     = (sel == 1) ? "R8" : (sel == 2) ? "R9" : (sel == 3) ? "R10" : "R7";
      repeat (2) @(negedge clk);
      run_model(int'(VEC[v][3:0]), VEC[v][6], sel, 70, stag);
    end

    // R4: drop run mid half period; idle level next clock, no strobes
    @(negedge clk) run = 1'b0;
    div_code = 4'd3; mode = 1'b1; samp_sel = 2'd1;
    repeat (2) @(negedge clk);
    run = 1'b1;
    repeat (4) @(negedge clk);
    mode = 1'b0;
    run = 1'b0;
    check(!shift_stb && !sample_stb, "R4", "strobes at run drop",
          int'(shift_stb) + int'(sample_stb), 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(sclk == 1'b0 && !shift_stb && !sample_stb, "R4", "idle after drop",
            int'(sclk) * 4 + int'(shift_stb) * 2 + int'(sample_stb), 0);
    end

    // R5: config changes while running are ignored until idle
    div_code = 4'd2; mode = 1'b0; samp_sel = 2'd0;
    repeat (2) @(negedge clk);
    fork
      run_model(2, 1'b0, 0, 40, "R5 R7");
      begin
        repeat (5) @(negedge clk);
        div_code = 4'd7;
        mode     = 1'b1;
      end
    join
    @(negedge clk) run = 1'b0;
    @(negedge clk);
    check(sclk == 1'b1, "R5", "new idle level after stop", sclk, 1);
    // new divide code applies on the next run
    run_model(7, 1'b1, 0, 30, "R5 R7");
    @(negedge clk) run = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule